// File: doc/BRIEF.md
# Thermometer Scratchpad and Function Command Layer

This block is the byte-level function layer of a single-wire temperature sensor slave. A bit-level bus engine, which also handles bus timing and device addressing, hands it each received byte and each bus reset. It asks for outgoing bytes one at a time. The block decodes the function command that follows addressing and runs it. The commands start a conversion, load the alarm limits and configuration, read the nine-byte scratchpad, copy the limits and configuration into nonvolatile storage, or report how the device is powered.

The scratchpad holds these bytes in order:

| Index | Content |
|-------|---------|
| 0, 1 | Temperature, low byte then high byte |
| 2 | High alarm limit |
| 3 | Low alarm limit |
| 4 | Configuration |
| 5 to 7 | Fixed reserved constants |
| 8 | CRC-8 over bytes 0 to 7 |

A conversion lasts a parameterised base time divided by 8, 4, 2 or 1, depending on the two-bit resolution code. When it ends, the sensor sample is stored with its unused fractional bits cleared. The nonvolatile copy survives the power-on reset, and that reset reloads the working limits and configuration from it.

Top module: `thermo_scratchpad`

## Requirements
- R1: After power-on reset the scratchpad reads temperature 0x0550, the high limit, low limit and resolution held in nonvolatile storage, and `busy` is 0. Before any copy, that storage holds 0x4B, 0x46 and resolution code 3.
- R2: After command 0xBE, each `tx_req` pulse yields `tx_valid` one cycle later. `tx_byte` then carries scratchpad bytes 0 to 7 in index order: temperature low, temperature high, high limit, low limit, configuration, then 0xFF, 0x0C and 0x10. Bit 0 of each byte goes out on the wire first.
- R3: The ninth byte read is the CRC-8 of bytes 0 to 7. It uses polynomial x^8+x^5+x^4+1, starts from zero, and takes each byte in from bit 0 upward, reflected.
- R4: Command 0x4E takes the next three bytes as high limit, low limit and configuration, in that order. The scratchpad changes only when the third byte arrives.
- R5: A bus reset before the third write byte discards the partial write, and the previous limits and configuration stay in place.
- R6: The configuration byte always reads bit 7 as 0 and bits 4:0 as 1. Bits 6:5 carry the resolution code last written, and the other written bits are ignored.
- R7: Command 0x44 raises `busy` on the next cycle. It stays high for exactly CONV_BASE/8, /4, /2 or /1 cycles for resolution code 0, 1, 2 or 3, taken at the start.
- R8: At the end of a conversion the temperature becomes `temp_in` with its low 3, 2, 1 or 0 bits cleared, for resolution code 0, 1, 2 or 3.
- R9: Command 0x48 copies the working limits and resolution into nonvolatile storage. Without a copy, a power-on reset brings back the old stored values.
- R10: After command 0xB4, each read request returns 0xFF when `ext_power` is 1 and 0x00 when it is 0.
- R11: Read requests beyond the ninth scratchpad byte, or with no read command active, return 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| bus_reset | input | 1 | Pulse: bus reset seen, next byte is a command |
| rx_valid | input | 1 | Pulse: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Pulse: engine needs the next byte to send |
| tx_valid | output | 1 | `tx_byte` answers the request of the previous cycle |
| tx_byte | output | 8 | Byte to send, bit 0 first |
| temp_in | input | 16 | Raw sensor sample, two's complement, 1/16 degree units |
| ext_power | input | 1 | 1 when externally supplied, 0 when parasite powered |
| busy | output | 1 | Conversion in progress |

## Verification
The bench writes two of the three limit bytes and then resets the bus. A design that committed each byte on arrival would read back a half-updated limit pair. It converts the same negative sample at all four resolutions and counts `busy` cycles each time. A wrong shift direction or a mask off by one bit shows up as a wrong length or a stray fractional bit. It power-cycles both with and without a prior copy, so a design that reset the nonvolatile copy, or copied on write, returns the wrong limits. It also reads past the CRC byte, where a design that wrapped the index would resend byte 0.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

   typedef enum logic [7:0] {
      CMD_CONVERT = 8'h44,
      CMD_WRITE   = 8'h4E,
      CMD_READ    = 8'hBE,
      CMD_COPY    = 8'h48,
      CMD_PWR     = 8'hB4
   } cmd_e;

   typedef enum logic [2:0] {
      S_CMD,
      S_WR,
      S_RD,
      S_PWR,
      S_DONE
   } state_e;

   // One byte through the reflected x^8+x^5+x^4+1 register, bit 0 first.
   function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] din);
      logic [7:0] c;
      c = crc;
      for (int i = 0; i < 8; i++) begin
         if (c[0] ^ din[i]) c = (c >> 1) ^ 8'h8C;
         else               c = c >> 1;
      end
      return c;
   endfunction

endpackage

// File: rtl/tsp_crc8.sv
module tsp_crc8 import tsp_pkg::*; (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       en,
   input  logic [7:0] din,
   output logic [7:0] crc
);
   logic [7:0] acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) acc_q <= '0;
      else if (en)       acc_q <= crc8_step(acc_q, din);
   end

   assign crc = acc_q;
endmodule

// File: rtl/tsp_conv_timer.sv
module tsp_conv_timer #(
   parameter int CONV_BASE = 750000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [1:0] res,
   output logic       busy,
   output logic       done,
   output logic [1:0] res_q
);
   localparam int CW = $clog2(CONV_BASE + 1);
   localparam logic [CW-1:0] BASE_V = CW'(CONV_BASE);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] len;
   logic          busy_q;

   assign len  = BASE_V >> (2'd3 - res);
   assign done = busy_q && (cnt_q == '0);
   assign busy = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         res_q  <= 2'd3;
      end else if (start && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= len - 1'b1;
         res_q  <= res;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/thermo_scratchpad.sv
module thermo_scratchpad import tsp_pkg::*; #(
   parameter int          CONV_BASE   = 750000,
   parameter logic [15:0] TEMP_POR    = 16'h0550,
   parameter logic [7:0]  NV_HI_INIT  = 8'h4B,
   parameter logic [7:0]  NV_LO_INIT  = 8'h46,
   parameter logic [1:0]  NV_RES_INIT = 2'b11,
   parameter logic [7:0]  RSV5        = 8'hFF,
   parameter logic [7:0]  RSV6        = 8'h0C,
   parameter logic [7:0]  RSV7        = 8'h10
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_reset,
   input  logic        rx_valid,
   input  logic [7:0]  rx_byte,
   input  logic        tx_req,
   output logic        tx_valid,
   output logic [7:0]  tx_byte,
   input  logic [15:0] temp_in,
   input  logic        ext_power,
   output logic        busy
);
   localparam int IDXW     = 4;
   localparam int SP_BYTES = 8;
   localparam int FRAC_MAX = 3;

   generate
      if (CONV_BASE < 8 || (CONV_BASE % 8) != 0) begin : g_bad_base
         $error("CONV_BASE must be a positive multiple of 8");
      end
   endgenerate

   state_e          state_q;
   logic [7:0]      th_q, tl_q;
   logic [1:0]      res_q;
   logic [15:0]     temp_q;
   logic [7:0]      nv_th  = NV_HI_INIT;
   logic [7:0]      nv_tl  = NV_LO_INIT;
   logic [1:0]      nv_res = NV_RES_INIT;
   logic [1:0]      wr_cnt;
   logic [7:0]      stg_th, stg_tl;
   logic [IDXW-1:0] rd_idx;
   logic [7:0]      sp_byte, cfg_rd, crc_val;
   logic [1:0]      conv_res;
   logic            conv_done;
   logic [15:0]     keep_mask;

   logic cmd_fire, conv_start, copy_go, rd_go, wr_fire, tx_sp;
   assign cmd_fire   = rx_valid && !bus_reset && (state_q == S_CMD);
   assign conv_start = cmd_fire && (rx_byte == CMD_CONVERT);
   assign copy_go    = rst_n && cmd_fire && (rx_byte == CMD_COPY);
   assign rd_go      = cmd_fire && (rx_byte == CMD_READ);
   assign wr_fire    = rx_valid && !bus_reset && (state_q == S_WR);
   assign tx_sp      = tx_req && (state_q == S_RD) && (rd_idx < IDXW'(SP_BYTES));

   assign cfg_rd = {1'b0, res_q, 5'h1F};

   always_comb begin
      case (rd_idx[2:0])
         3'd0:    sp_byte = temp_q[7:0];
         3'd1:    sp_byte = temp_q[15:8];
         3'd2:    sp_byte = th_q;
         3'd3:    sp_byte = tl_q;
         3'd4:    sp_byte = cfg_rd;
         3'd5:    sp_byte = RSV5;
         3'd6:    sp_byte = RSV6;
         default: sp_byte = RSV7;
      endcase
   end

   // Fractional bit i survives when the resolution code is at least 3-i.
   genvar gi;
   generate
      for (gi = 0; gi < FRAC_MAX; gi++) begin : g_mask
         assign keep_mask[gi] = (conv_res >= 2'(FRAC_MAX - gi));
      end
   endgenerate
   assign keep_mask[15:FRAC_MAX] = '1;

   tsp_conv_timer #(.CONV_BASE(CONV_BASE)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (conv_start),
      .res   (res_q),
      .busy  (busy),
      .done  (conv_done),
      .res_q (conv_res)
   );

   tsp_crc8 u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rd_go),
      .en    (tx_sp),
      .din   (sp_byte),
      .crc   (crc_val)
   );

   // Nonvolatile shadow: untouched by power-on reset.
   always_ff @(posedge clk) begin
      if (copy_go) begin
         nv_th  <= th_q;
         nv_tl  <= tl_q;
         nv_res <= res_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_CMD;
         th_q    <= nv_th;
         tl_q    <= nv_tl;
         res_q   <= nv_res;
         temp_q  <= TEMP_POR;
         wr_cnt  <= '0;
         stg_th  <= '0;
         stg_tl  <= '0;
         rd_idx  <= '0;
      end else begin
         if (conv_done) temp_q <= temp_in & keep_mask;
         if (bus_reset) begin
            state_q <= S_CMD;
            wr_cnt  <= '0;
         end else if (cmd_fire) begin
            rd_idx <= '0;
            wr_cnt <= '0;
            case (rx_byte)
               CMD_WRITE: state_q <= S_WR;
               CMD_READ:  state_q <= S_RD;
               CMD_PWR:   state_q <= S_PWR;
               default:   state_q <= S_DONE;
            endcase
         end else if (wr_fire) begin
            case (wr_cnt)
               2'd0:    stg_th <= rx_byte;
               2'd1:    stg_tl <= rx_byte;
               default: begin
                  th_q    <= stg_th;
                  tl_q    <= stg_tl;
                  res_q   <= rx_byte[6:5];
                  state_q <= S_DONE;
               end
            endcase
            wr_cnt <= wr_cnt + 1'b1;
         end
         if (tx_req && state_q == S_RD && rd_idx <= IDXW'(SP_BYTES))
            rd_idx <= rd_idx + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_byte  <= 8'hFF;
      end else begin
         tx_valid <= tx_req;
         if (tx_req) begin
            if (tx_sp)                                          tx_byte <= sp_byte;
            else if (state_q == S_RD && rd_idx == IDXW'(SP_BYTES)) tx_byte <= crc_val;
            else if (state_q == S_PWR)                          tx_byte <= {8{ext_power}};
            else                                                tx_byte <= 8'hFF;
         end
      end
   end
endmodule

// File: rtl/tsp_checker.sv
module tsp_checker #(
   parameter int CONV_BASE = 750000
) (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_reset,
   input logic        tx_req,
   input logic        tx_valid,
   input logic        busy,
   input logic [7:0]  th_q,
   input logic [7:0]  tl_q,
   input logic [1:0]  res_q,
   input logic [1:0]  conv_res,
   input logic [15:0] temp_q
);
   localparam int CW = $clog2(CONV_BASE + 2);
   localparam logic [CW-1:0] BASE_V = CW'(CONV_BASE);

   logic [CW-1:0] run_q;
   logic [15:0]   low_bits;

   always_ff @(posedge clk) begin
      if (!rst_n)    run_q <= '0;
      else if (busy) run_q <= run_q + 1'b1;
      else           run_q <= '0;
   end

   assign low_bits = (16'd1 << (2'd3 - conv_res)) - 16'd1;

   p_tx_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |=> tx_valid);

   p_tx_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_req |=> !tx_valid);

   p_write_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> ($stable(th_q) && $stable(tl_q) && $stable(res_q)));

   p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_q == (BASE_V >> (2'd3 - conv_res))));

   p_frac_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ((temp_q & low_bits) == 16'd0));
endmodule

bind thermo_scratchpad tsp_checker #(.CONV_BASE(CONV_BASE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_reset (bus_reset),
   .tx_req    (tx_req),
   .tx_valid  (tx_valid),
   .busy      (busy),
   .th_q      (th_q),
   .tl_q      (tl_q),
   .res_q     (res_q),
   .conv_res  (conv_res),
   .temp_q    (temp_q)
);

// File: tb/thermo_scratchpad_bench.sv
module thermo_scratchpad_bench;
   localparam int BASE = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_reset = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic        tx_req = 1'b0;
   logic        tx_valid;
   logic [7:0]  tx_byte;
   logic [15:0] temp_in = 16'h0000;
   logic        ext_power = 1'b1;
   logic        busy;

   int errors = 0;
   int checks = 0;
   logic [7:0] exp_sp [0:7];

   always #2 clk = ~clk;

   thermo_scratchpad #(.CONV_BASE(BASE)) u_thermo_scratchpad (
      .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .tx_req(tx_req), .tx_valid(tx_valid), .tx_byte(tx_byte),
      .temp_in(temp_in), .ext_power(ext_power), .busy(busy)
   );

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] crc_ref(input logic [7:0] c0, input logic [7:0] b);
      logic [7:0] c = c0;
      for (int k = 0; k < 8; k++) begin
         logic fb = c[0] ^ b[k];
         c = {1'b0, c[7:1]};
         if (fb) c = c ^ 8'b1000_1100;
      end
      return c;
   endfunction

   task automatic breset();
      @(negedge clk) bus_reset = 1'b1;
      @(negedge clk) bus_reset = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; end
      @(negedge clk) rx_valid = 1'b0;
   endtask

   task automatic fetch(output logic [7:0] b, output logic v);
      @(negedge clk) tx_req = 1'b1;
      @(negedge clk) tx_req = 1'b0;
      b = tx_byte;
      v = tx_valid;
   endtask

   task automatic power_cycle();
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
   endtask

   task automatic set_exp(input logic [15:0] t, input logic [7:0] hi,
                          input logic [7:0] lo, input logic [7:0] cfg);
      exp_sp[0] = t[7:0]; exp_sp[1] = t[15:8]; exp_sp[2] = hi; exp_sp[3] = lo;
      exp_sp[4] = cfg; exp_sp[5] = 8'hFF; exp_sp[6] = 8'h0C; exp_sp[7] = 8'h10;
   endtask

   // R2 R3: read all nine bytes and compare.
   task automatic read_sp(input string tag);
      logic [7:0] b, c;
      logic v;
      c = 8'h00;
      breset();
      send(8'hBE);
      for (int i = 0; i < 8; i++) begin
         fetch(b, v);
         chk($sformatf("%s R2 valid byte %0d", tag, i), int'(v), 1);
         chk($sformatf("%s R2 byte %0d", tag, i), int'(b), int'(exp_sp[i]));
         c = crc_ref(c, exp_sp[i]);
      end
      fetch(b, v);
      chk($sformatf("%s R3 crc", tag), int'(b), int'(c));
      chk($sformatf("%s R3 residue", tag), int'(crc_ref(c, b)), 0);
   endtask

   task automatic write3(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] cfg);
      breset();
      send(8'h4E);
      send(hi);
      send(lo);
      send(cfg);
   endtask

   task automatic t_reset();
      chk("R1 busy at reset", int'(busy), 0);
      chk("R1 tx_valid at reset", int'(tx_valid), 0);
      set_exp(16'h0550, 8'h4B, 8'h46, 8'h7F);
      read_sp("R1 power-on");
   endtask

   task automatic t_power();
      logic [7:0] b;
      logic v;
      breset();
      send(8'hB4);
      ext_power = 1'b1;
      fetch(b, v);
      chk("R10 external supply", int'(b), 8'hFF);
      ext_power = 1'b0;
      fetch(b, v);
      chk("R10 parasite supply", int'(b), 8'h00);
      ext_power = 1'b1;
   endtask

   task automatic t_write();
      write3(8'h19, 8'hF6, 8'h1F);
      set_exp(16'h0550, 8'h19, 8'hF6, 8'h1F);
      read_sp("R4 write res0");
      write3(8'h7D, 8'h80, 8'hC0);
      set_exp(16'h0550, 8'h7D, 8'h80, 8'h5F);
      read_sp("R6 cfg forced bits");
   endtask

   task automatic t_partial();
      breset();
      send(8'h4E);
      send(8'h01);
      send(8'h02);
      breset();
      read_sp("R5 partial write discarded");
   endtask

   task automatic t_convert(input logic [1:0] r);
      int n;
      logic [15:0] m;
      write3(8'h7D, 8'h80, {1'b0, r, 5'b0});
      temp_in = 16'hFF6F;
      breset();
      send(8'h44);
      n = 0;
      while (busy) begin
         n++;
         @(negedge clk);
      end
      chk($sformatf("R7 busy cycles res%0d", r), n, BASE >> (3 - int'(r)));
      m = 16'hFFFF << (3 - int'(r));
      set_exp(16'hFF6F & m, 8'h7D, 8'h80, {1'b0, r, 5'h1F});
      read_sp($sformatf("R8 masked res%0d", r));
   endtask

   task automatic t_overrun();
      logic [7:0] b;
      logic v;
      fetch(b, v);
      chk("R11 tenth byte", int'(b), 8'hFF);
      breset();
      fetch(b, v);
      chk("R11 no command", int'(b), 8'hFF);
   endtask

   task automatic t_recall();
      write3(8'h11, 8'h22, 8'h3F);
      power_cycle();
      set_exp(16'h0550, 8'h4B, 8'h46, 8'h7F);
      read_sp("R9 no copy recall");
      write3(8'h11, 8'h22, 8'h3F);
      breset();
      send(8'h48);
      power_cycle();
      chk("R1 busy after power cycle", int'(busy), 0);
      set_exp(16'h0550, 8'h11, 8'h22, 8'h3F);
      read_sp("R9 copy recall");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_power();
      t_write();
      t_partial();
      for (int r = 0; r < 4; r++) t_convert(2'(r));
      t_overrun();
      t_recall();
      report();
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
   end
endmodule